// File: doc/BRIEF.md
# Processor exception entry controller

This block performs exception entry for a 32-bit system-control coprocessor. Fault and interrupt requests arrive as a one-bit-per-cause vector, together with the faulting instruction's PC, the next PC, the offending data or fetch address and a coprocessor number. On the clock edge after a request, the block selects one cause by fixed priority. In that same edge it updates the status, cause, exception-PC, bad-address, translation-entry-high, page-context and shadow-set control registers. It also redirects the fetch PC triplet to the handler.

The handler address depends on the kind of cause, on the boot-vector bit, on the interrupt-vector bit of the cause register, and on the exception-level bit as it stood before entry. Entry from normal mode also swaps the active shadow register set. Software reads these registers and writes them back through a simple register port. A software write that coincides with an entry is dropped.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bits are indexed 0 boot-reset, 1 load/fetch address error, 2 store address error, 3 load TLB refill, 4 store TLB refill, 5 load TLB invalid, 6 store TLB invalid, 7 TLB modified, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow, 13 trap, 14 interrupt. When several bits are set, the lowest index alone is taken.
- R2: Every non-reset entry sets status bit 1 (exception level) to 1 and leaves the other status bits unchanged. A boot-reset request sets status bit 22 (boot vector) and changes nothing else.
- R3: Shadow-set control holds the current set in bits 3:0, the previous set in bits 9:6 and the exception set in bits 15:12. On entry with status bits 1 and 22 both 0, the previous set takes the current set and the current set takes the exception set. Otherwise the register is unchanged. shadow_set_o shows the current set.
- R4: If pc_i + 4 differs from npc_i, the exception PC gets pc_i - 4 and cause bit 31 is set to 1. Otherwise the exception PC gets pc_i and cause bit 31 is cleared.
- R5: Cause bits 6:2 get the code for the cause taken: interrupt 0x0, TLB modified 0x1, load TLB 0x2, store TLB 0x3, load address error 0x4, store address error 0x5, syscall 0x8, breakpoint 0x9, reserved 0xA, coprocessor unusable 0xB, overflow 0xC, trap 0xD. Cause bits 29:28 get cop_id_i for coprocessor unusable and 0 for every other cause. Cause bit 23 is kept.
- R6: With status bit 22 set, every non-reset entry goes to 0xBFC00200. Otherwise the general handler is base + 0x180, where base is the base register.
- R7: A TLB refill goes to base + 0x000 when the exception level was 0 before entry, and to base + 0x180 when it was already 1.
- R8: An interrupt goes to base + 0x200 when cause bit 23 is 1, and to base + 0x180 when it is 0.
- R9: At power-on reset the PC triplet is 0xBFC00000, +4, +8, and a boot-reset request loads the same triplet. On entry the triplet becomes handler, handler + 4, handler + 8.
- R10: Address-error and TLB causes load the bad-address register with bad_addr_i. TLB causes also load entry-high bits 31:13 and context bits 22:4 from bad_addr_i bits 31:13, and keep the ASID in entry-high bits 7:0. Other causes leave these registers unchanged.
- R11: Register addresses are 0 status, 1 cause, 2 exception PC, 3 bad address, 4 entry-high, 5 context, 6 shadow-set control, 7 base. Bits 11:0 of the base register always read 0. Reads are combinational, and writes land on the next edge. A write in a cycle with any request is ignored. redirect_o pulses for one cycle after each request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 15 | Cause request bits, indexed as in R1 |
| pc_i | input | 32 | PC of the faulting instruction |
| npc_i | input | 32 | Next PC at the time of the fault |
| bad_addr_i | input | 32 | Offending address |
| cop_id_i | input | 2 | Coprocessor number for coprocessor-unusable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| redirect_o | output | 1 | Fetch redirect pulse |
| pc_o | output | 32 | Redirected PC |
| npc_o | output | 32 | Redirected next PC |
| nnpc_o | output | 32 | Redirected next-next PC |
| shadow_set_o | output | 4 | Active shadow register set |

## Verification
The assertions check on every cycle that at most one cause is granted and that the exception-level bit is set after each entry. They also check that the shadow-set control holds still when entry happens from exception or boot mode, that a delay-slot fault sets the branch-delay bit, that the redirect pulse follows each request, and that the PC triplet stays evenly spaced. Only the bench scenarios can show the exact handler address for each combination of boot-vector bit, pre-entry exception level and interrupt-vector bit. The same holds for the code and coprocessor field written for each cause, for the address capture into the translation registers, and for a software write being dropped when it collides with an entry.

// File: rtl/exc_pkg.sv
`timescale 1ns / 1ps
package exc_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NUM_SRC = 15;
  localparam int unsigned SRC_W   = $clog2(NUM_SRC);

  localparam logic [SRC_W-1:0] SRC_BOOT  = 4'd0;
  localparam logic [SRC_W-1:0] SRC_ADEL  = 4'd1;
  localparam logic [SRC_W-1:0] SRC_ADES  = 4'd2;
  localparam logic [SRC_W-1:0] SRC_RFL_L = 4'd3;
  localparam logic [SRC_W-1:0] SRC_RFL_S = 4'd4;
  localparam logic [SRC_W-1:0] SRC_INV_L = 4'd5;
  localparam logic [SRC_W-1:0] SRC_INV_S = 4'd6;
  localparam logic [SRC_W-1:0] SRC_MOD   = 4'd7;
  localparam logic [SRC_W-1:0] SRC_SYS   = 4'd8;
  localparam logic [SRC_W-1:0] SRC_BRK   = 4'd9;
  localparam logic [SRC_W-1:0] SRC_RSV   = 4'd10;
  localparam logic [SRC_W-1:0] SRC_COPU  = 4'd11;
  localparam logic [SRC_W-1:0] SRC_OVF   = 4'd12;
  localparam logic [SRC_W-1:0] SRC_TRAP  = 4'd13;
  localparam logic [SRC_W-1:0] SRC_IRQ   = 4'd14;

  // field positions software decodes
  localparam int unsigned ST_EXL  = 1;
  localparam int unsigned ST_BEV  = 22;
  localparam int unsigned CA_BD   = 31;
  localparam int unsigned CA_IV   = 23;
  localparam int unsigned CA_CE_LO = 28;
  localparam int unsigned CA_EC_LO = 2;
  localparam int unsigned VPN_LO  = 13;
  localparam int unsigned CTX_LO  = 4;
  localparam int unsigned SS_CUR  = 0;
  localparam int unsigned SS_PRV  = 6;
  localparam int unsigned SS_EXC  = 12;
  localparam int unsigned SS_W    = 4;
  localparam int unsigned VPN_W   = XLEN - VPN_LO;

  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_CAUSE  = 3'd1,
    REG_EPC    = 3'd2,
    REG_BADVA  = 3'd3,
    REG_ENTHI  = 3'd4,
    REG_CTX    = 3'd5,
    REG_SSCTL  = 3'd6,
    REG_BASE   = 3'd7
  } reg_sel_e;

  function automatic logic [4:0] exc_code(input logic [SRC_W-1:0] s);
    case (s)
      SRC_MOD:              exc_code = 5'h01;
      SRC_RFL_L, SRC_INV_L: exc_code = 5'h02;
      SRC_RFL_S, SRC_INV_S: exc_code = 5'h03;
      SRC_ADEL:             exc_code = 5'h04;
      SRC_ADES:             exc_code = 5'h05;
      SRC_SYS:              exc_code = 5'h08;
      SRC_BRK:              exc_code = 5'h09;
      SRC_RSV:              exc_code = 5'h0A;
      SRC_COPU:             exc_code = 5'h0B;
      SRC_OVF:              exc_code = 5'h0C;
      SRC_TRAP:             exc_code = 5'h0D;
      default:              exc_code = 5'h00;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
`timescale 1ns / 1ps
module exc_prio_sel #(
  parameter int unsigned N = 15,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         valid_o,
  output logic [W-1:0] idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_gnt
    if (g == 0) begin : g_first
      assign grant_o[g] = req_i[g];
    end else begin : g_rest
      assign grant_o[g] = req_i[g] & ~(|req_i[g-1:0]);
    end
  end

  assign valid_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (grant_o[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/exc_vector_sel.sv
`timescale 1ns / 1ps
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] BEV_VEC = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] GEN_OFS = 32'h0000_0180,
  parameter logic [XLEN-1:0] IRQ_OFS = 32'h0000_0200
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic             bev_i,
  input  logic             iv_i,
  input  logic             exl_old_i,
  input  logic [XLEN-1:0]  base_i,
  output logic [XLEN-1:0]  handler_o
);
  logic is_refill;
  assign is_refill = (src_i == SRC_RFL_L) || (src_i == SRC_RFL_S);

  always_comb begin
    if (bev_i)                        handler_o = BEV_VEC;
    else if (is_refill && !exl_old_i) handler_o = base_i;
    else if (src_i == SRC_IRQ && iv_i) handler_o = base_i + IRQ_OFS;
    else                              handler_o = base_i + GEN_OFS;
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns / 1ps
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] BOOT_VEC   = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BEV_VEC    = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] BASE_RST   = 32'h8000_0000,
  parameter logic [XLEN-1:0] STATUS_RST = 32'h0040_0000,
  parameter int unsigned     INSN_BYTES = 4,
  parameter int unsigned     CE_W       = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] exc_req_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    npc_i,
  input  logic [XLEN-1:0]    bad_addr_i,
  input  logic [CE_W-1:0]    cop_id_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [XLEN-1:0]    reg_wdata_i,
  output logic [XLEN-1:0]    reg_rdata_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    pc_o,
  output logic [XLEN-1:0]    npc_o,
  output logic [XLEN-1:0]    nnpc_o,
  output logic [SS_W-1:0]    shadow_set_o
);
  localparam logic [XLEN-1:0] STEP     = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] BASE_MSK = 32'hFFFF_F000;

  logic [XLEN-1:0] status_q, cause_q, epc_q, badva_q, enthi_q, ctx_q, ssctl_q, base_q;
  logic [XLEN-1:0] pc_q, npc_q, nnpc_q;
  logic            redirect_q;

  logic [NUM_SRC-1:0] grant;
  logic               take;
  logic [SRC_W-1:0]   src;

  exc_prio_sel #(.N(NUM_SRC)) u_prio (
    .req_i  (exc_req_i),
    .grant_o(grant),
    .valid_o(take),
    .idx_o  (src)
  );

  logic exl_old, bev;
  logic [XLEN-1:0] handler;
  assign exl_old = status_q[ST_EXL];
  assign bev     = status_q[ST_BEV];

  exc_vector_sel #(.BEV_VEC(BEV_VEC)) u_vec (
    .src_i    (src),
    .bev_i    (bev),
    .iv_i     (cause_q[CA_IV]),
    .exl_old_i(exl_old),
    .base_i   (base_q),
    .handler_o(handler)
  );

  logic is_boot, is_exc, is_tlb, is_addr, in_slot;
  assign is_boot = take && (src == SRC_BOOT);
  assign is_exc  = take && (src != SRC_BOOT);
  assign is_tlb  = (src >= SRC_RFL_L) && (src <= SRC_MOD);
  assign is_addr = (src == SRC_ADEL) || (src == SRC_ADES);
  assign in_slot = (pc_i + STEP) != npc_i;

  logic [XLEN-1:0] cause_d, ssctl_d, epc_d;
  always_comb begin
    cause_d = cause_q;
    cause_d[CA_EC_LO +: 5]   = exc_code(src);
    cause_d[CA_BD]           = in_slot;
    cause_d[CA_CE_LO +: CE_W] = (src == SRC_COPU) ? cop_id_i : '0;
    ssctl_d = ssctl_q;
    if (!exl_old && !bev) begin
      ssctl_d[SS_PRV +: SS_W] = ssctl_q[SS_CUR +: SS_W];
      ssctl_d[SS_CUR +: SS_W] = ssctl_q[SS_EXC +: SS_W];
    end
    epc_d = in_slot ? (pc_i - STEP) : pc_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= STATUS_RST;
      cause_q    <= '0;
      epc_q      <= '0;
      badva_q    <= '0;
      enthi_q    <= '0;
      ctx_q      <= '0;
      ssctl_q    <= '0;
      base_q     <= BASE_RST & BASE_MSK;
      pc_q       <= BOOT_VEC;
      npc_q      <= BOOT_VEC + STEP;
      nnpc_q     <= BOOT_VEC + 2 * STEP;
      redirect_q <= 1'b0;
    end else begin
      redirect_q <= take;
      if (is_boot) begin
        status_q[ST_BEV] <= 1'b1;
        pc_q   <= BOOT_VEC;
        npc_q  <= BOOT_VEC + STEP;
        nnpc_q <= BOOT_VEC + 2 * STEP;
      end else if (is_exc) begin
        status_q[ST_EXL] <= 1'b1;
        ssctl_q <= ssctl_d;
        cause_q <= cause_d;
        epc_q   <= epc_d;
        if (is_addr || is_tlb) badva_q <= bad_addr_i;
        if (is_tlb) begin
          enthi_q[VPN_LO +: VPN_W] <= bad_addr_i[VPN_LO +: VPN_W];
          ctx_q[CTX_LO +: VPN_W]   <= bad_addr_i[VPN_LO +: VPN_W];
        end
        pc_q   <= handler;
        npc_q  <= handler + STEP;
        nnpc_q <= handler + 2 * STEP;
      end else if (reg_we_i) begin
        case (reg_sel_e'(reg_addr_i))
          REG_STATUS: status_q <= reg_wdata_i;
          REG_CAUSE:  cause_q  <= reg_wdata_i;
          REG_EPC:    epc_q    <= reg_wdata_i;
          REG_BADVA:  badva_q  <= reg_wdata_i;
          REG_ENTHI:  enthi_q  <= reg_wdata_i;
          REG_CTX:    ctx_q    <= reg_wdata_i;
          REG_SSCTL:  ssctl_q  <= reg_wdata_i;
          default:    base_q   <= reg_wdata_i & BASE_MSK;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_addr_i))
      REG_STATUS: reg_rdata_o = status_q;
      REG_CAUSE:  reg_rdata_o = cause_q;
      REG_EPC:    reg_rdata_o = epc_q;
      REG_BADVA:  reg_rdata_o = badva_q;
      REG_ENTHI:  reg_rdata_o = enthi_q;
      REG_CTX:    reg_rdata_o = ctx_q;
      REG_SSCTL:  reg_rdata_o = ssctl_q;
      default:    reg_rdata_o = base_q;
    endcase
  end

  assign redirect_o   = redirect_q;
  assign pc_o         = pc_q;
  assign npc_o        = npc_q;
  assign nnpc_o       = nnpc_q;
  assign shadow_set_o = ssctl_q[SS_CUR +: SS_W];
endmodule

// File: rtl/exc_entry_chk.sv
`timescale 1ns / 1ps
module exc_entry_chk
  import exc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_SRC-1:0] exc_req_i,
  input logic [XLEN-1:0]    pc_i,
  input logic [XLEN-1:0]    npc_i,
  input logic               redirect_o,
  input logic [XLEN-1:0]    pc_o,
  input logic [XLEN-1:0]    npc_o,
  input logic [XLEN-1:0]    nnpc_o,
  input logic [XLEN-1:0]    status_q,
  input logic [XLEN-1:0]    cause_q,
  input logic [XLEN-1:0]    ssctl_q,
  input logic [NUM_SRC-1:0] grant
);
  logic exc_take;
  assign exc_take = (|exc_req_i) && !exc_req_i[0];

  assert_one_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_exl_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> status_q[ST_EXL]);

  assert_ss_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take && (status_q[ST_EXL] || status_q[ST_BEV])) |=> $stable(ssctl_q));

  assert_bd_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_take && (pc_i + 32'd4 != npc_i)) |=> cause_q[CA_BD]);

  assert_triplet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> (npc_o == pc_o + 32'd4 && nnpc_o == pc_o + 32'd8));

  assert_redirect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|exc_req_i) |=> redirect_o);
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .exc_req_i (exc_req_i),
  .pc_i      (pc_i),
  .npc_i     (npc_i),
  .redirect_o(redirect_o),
  .pc_o      (pc_o),
  .npc_o     (npc_o),
  .nnpc_o    (nnpc_o),
  .status_q  (status_q),
  .cause_q   (cause_q),
  .ssctl_q   (ssctl_q),
  .grant     (grant)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns / 1ps
module exc_entry_ctrl_test;
  localparam logic [31:0] BOOT = 32'hBFC0_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [14:0] exc_req_i = '0;
  logic [31:0] pc_i = '0, npc_i = '0, bad_addr_i = '0, reg_wdata_i = '0;
  logic [1:0]  cop_id_i = '0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_rdata_o, pc_o, npc_o, nnpc_o;
  logic        redirect_o;
  logic [3:0]  shadow_set_o;

  always #2.5 clk = ~clk;

  exc_entry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .exc_req_i(exc_req_i), .pc_i(pc_i), .npc_i(npc_i),
    .bad_addr_i(bad_addr_i), .cop_id_i(cop_id_i), .reg_we_i(reg_we_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .redirect_o(redirect_o), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .shadow_set_o(shadow_set_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_reg [8];
  logic [31:0] m_pc;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int pick(input logic [14:0] r);
    for (int i = 0; i < 15; i++) if (r[i]) return i;
    return -1;
  endfunction

  function automatic logic [4:0] code_of(input int s);
    case (s)
      1: return 5'h4;  2: return 5'h5;  3, 5: return 5'h2;  4, 6: return 5'h3;
      7: return 5'h1;  8: return 5'h8;  9: return 5'h9;  10: return 5'hA;
      11: return 5'hB; 12: return 5'hC; 13: return 5'hD; default: return 5'h0;
    endcase
  endfunction

  function automatic logic [31:0] vec_of(input int s, input logic bev, input logic exl,
                                         input logic iv, input logic [31:0] eb);
    if (bev) return 32'hBFC0_0200;
    if ((s == 3 || s == 4) && !exl) return eb;
    if (s == 14 && iv) return eb + 32'h200;
    return eb + 32'h180;
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0: return "R2"; 1: return "R5"; 2: return "R4"; 6: return "R3";
      7: return "R11"; default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [14:0] req, input logic [31:0] pc, input logic [31:0] npc,
                       input logic [31:0] bad, input logic [1:0] cop, input logic we,
                       input logic [2:0] addr, input logic [31:0] wd);
    int s = pick(req);
    if (s == 0) begin
      m_reg[0][22] = 1'b1;
      m_pc = BOOT;
    end else if (s > 0) begin
      logic exl = m_reg[0][1];
      logic bev = m_reg[0][22];
      logic bd = (pc + 32'd4) != npc;
      m_pc = vec_of(s, bev, exl, m_reg[1][23], m_reg[7]);
      m_reg[0][1] = 1'b1;
      if (!exl && !bev) begin
        m_reg[6][9:6] = m_reg[6][3:0];
        m_reg[6][3:0] = m_reg[6][15:12];
      end
      m_reg[2] = bd ? pc - 32'd4 : pc;
      m_reg[1][6:2] = code_of(s);
      m_reg[1][31] = bd;
      m_reg[1][29:28] = (s == 11) ? cop : 2'b00;
      if (s >= 1 && s <= 7) m_reg[3] = bad;
      if (s >= 3 && s <= 7) begin
        m_reg[4][31:13] = bad[31:13];
        m_reg[5][22:4]  = bad[31:13];
      end
    end else if (we) begin
      m_reg[addr] = (addr == 3'd7) ? (wd & 32'hFFFF_F000) : wd;
    end
  endtask

  task automatic read_all();
    for (int a = 0; a < 8; a++) begin
      reg_addr_i = a[2:0];
      #0.2;
      chk(reg_rdata_o, m_reg[a], tag_of(a));
    end
    chk({28'd0, shadow_set_o}, {28'd0, m_reg[6][3:0]}, "R3");
  endtask

  task automatic step(input logic [14:0] req, input logic [31:0] pc, input logic [31:0] npc,
                      input logic [31:0] bad, input logic [1:0] cop, input logic we,
                      input logic [2:0] addr, input logic [31:0] wd, input string tag);
    @(negedge clk);
    exc_req_i = req; pc_i = pc; npc_i = npc; bad_addr_i = bad; cop_id_i = cop;
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    model(req, pc, npc, bad, cop, we, addr, wd);
    @(posedge clk);
    #0.5;
    exc_req_i = '0; reg_we_i = 1'b0;
    chk({31'd0, redirect_o}, {31'd0, req != 0}, "R11");
    chk(pc_o, m_pc, tag);
    chk(npc_o, m_pc + 32'd4, "R9");
    chk(nnpc_o, m_pc + 32'd8, "R9");
    read_all();
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step('0, 0, 4, 0, 0, 1'b1, a, d, "R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep;
    void'($urandom(32'd20240611));
    for (int a = 0; a < 8; a++) m_reg[a] = '0;
    m_reg[0] = 32'h0040_0000;
    m_reg[7] = 32'h8000_0000;
    m_pc = BOOT;
    repeat (3) @(posedge clk);
    #0.5;
    // R9 reset state
    chk(pc_o, BOOT, "R9");
    chk(nnpc_o, BOOT + 32'd8, "R9");
    read_all();
    @(negedge clk); rst_ni = 1'b1;

    wr(3'd7, 32'h8000_1ABC);          // R11 low bits masked
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0000_5002);
    // R3 swap + R6 general vector
    step(15'h0100, 32'h1000, 32'h1004, 0, 0, 0, 0, 0, "R6");
    // R7 refill with exception level already set
    step(15'h0008, 32'h2000, 32'h2004, 32'h1234_5678, 0, 0, 0, 0, "R7");
    // R7 refill from normal mode, delay slot (R4)
    wr(3'd0, 32'h0);
    step(15'h0010, 32'h3000, 32'h3040, 32'hFEDC_B000, 0, 0, 0, 0, "R7");
    // R8 interrupt with vector bit set, then clear
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0080_0000);
    step(15'h4000, 32'h4000, 32'h4004, 0, 0, 0, 0, 0, "R8");
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    step(15'h4000, 32'h4100, 32'h4104, 0, 0, 0, 0, 0, "R8");
    // R5 coprocessor number
    step(15'h0800, 32'h5000, 32'h5004, 0, 2'd3, 0, 0, 0, "R5");
    // R1 several requests: store address error wins
    step(15'h4204 | 15'h0200, 32'h6000, 32'h6004, 32'hAAAA_5555, 0, 0, 0, 0, "R1");
    // R11 write colliding with entry is dropped
    keep = m_reg[3];
    step(15'h1000, 32'h7000, 32'h7004, 0, 0, 1'b1, 3'd3, 32'hDEAD_BEEF, "R6");
    reg_addr_i = 3'd3; #0.1;
    chk(reg_rdata_o, keep, "R11");
    // R6 boot-vector mode
    wr(3'd0, 32'h0040_0000);
    step(15'h2000, 32'h8000, 32'h8004, 0, 0, 0, 0, 0, "R6");
    // R9 boot-reset request
    step(15'h0001, 32'h9000, 32'h9004, 0, 0, 0, 0, 0, "R9");

    for (int n = 0; n < 600; n++) begin
      logic [14:0] rq;
      logic [31:0] pc, npc;
      int k = $urandom_range(0, 9);
      if (k < 5) rq = '0;
      else if (k < 8) rq = 15'(1) << $urandom_range(1, 14);
      else rq = 15'($urandom) & 15'h7FFE;
      if ($urandom_range(0, 40) == 0) rq[0] = 1'b1;
      pc = $urandom & 32'hFFFF_FFFC;
      npc = $urandom_range(0, 1) ? pc + 32'd4 : ($urandom & 32'hFFFF_FFFC);
      step(rq, pc, npc, $urandom, 2'($urandom), 1'($urandom), 3'($urandom),
           ($urandom_range(0, 2) == 0) ? 32'h0 : $urandom, "R6");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule